// File: doc/BRIEF.md
# Keyed-Disable Watchdog Timer

This block guards a device against runaway software. A counter advances on a slow watchdog tick. When it reaches the selected time-out, it raises a reset request for the rest of the device. Software must pulse a clear strobe often enough to keep the counter from reaching its limit.

The tick comes from one of two sources, picked by a configuration input:
- the system clock divided by four, or
- the rising edges of a slow sub-clock, which are first synchronised into the system clock domain.

A second configuration input sets the time-out to one of four successive powers of two. A configuration-level enable gates the whole block.

On top of the configuration enable, a 4-bit run-time field controls the watchdog:
- The field holds the value 1010 after reset. That value, and only that value, keeps the counter stopped.
- Any other value lets it run.
- Writing a running value always restarts the count from zero.

All logic runs on the system clock. The watchdog clock is expressed as a one-cycle tick rather than a separate clock net.

Top module: `keyed_watchdog`

## Requirements
- R1: While running, the counter advances by one per watchdog tick. On the tick that ends a full time-out period, measured from the last restart, clear or overflow, `wdt_rst_req` goes high one system clock later.
- R2: With `cfg_src_sel` = 0 the watchdog tick occurs once every four system clocks. With `cfg_src_sel` = 1 it occurs once per rising edge of `sub_clk`. That edge takes effect on the third system clock edge after it is first sampled, and no tick occurs without such an edge.
- R3: `cfg_tmo_sel` values 0, 1, 2 and 3 give time-outs of 2^(B), 2^(B+1), 2^(B+2) and 2^(B+3) ticks, where B is `TMO_BASE_EXP` (default 13). Value 3 is the longest.
- R4: The counter is held at zero exactly when `field_q` equals 4'b1010. Every one of the other fifteen values lets the watchdog run to a request.
- R5: After reset `field_q` reads 4'b1010 and no request is raised, even with the configuration enable high.
- R6: With `cfg_wdt_en` low the counter stays at zero, `clr_wdt` has no effect, and no request is raised.
- R7: A `clr_wdt` pulse while enabled returns the counter to zero on the next system clock edge.
- R8: A write (`key_we` high) of any value other than 4'b1010 returns the counter to zero and restarts the full time-out, even if the watchdog was already running.
- R9: Once raised, `wdt_rst_req` stays high until the next watchdog tick of the selected source after the overflow tick. It then drops, so it spans one full watchdog clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sub_clk | input | 1 | Slow sub-clock, asynchronous to clk |
| cfg_wdt_en | input | 1 | Configuration-level watchdog enable |
| cfg_src_sel | input | 1 | Tick source: 0 = system clock / 4, 1 = sub-clock edges |
| cfg_tmo_sel | input | 2 | Time-out select, 2^(B+value) ticks |
| key_we | input | 1 | Write strobe for the run-time enable field |
| key_wdata | input | 4 | Value written to the run-time enable field |
| clr_wdt | input | 1 | Clear-watchdog strobe |
| field_q | output | 4 | Current run-time enable field |
| wdt_rst_req | output | 1 | Device reset request |

## Verification
The properties assume three things about the inputs:
- `sub_clk` is slow enough that each of its levels lasts at least two system clocks, so that every rising edge yields exactly one tick.
- The configuration inputs change only while the counter is stopped or far from its limit.
- `key_wdata` is valid whenever `key_we` is high.

The stimulus keeps to these rules in a few ways. It holds each sub-clock level for three system clocks. It changes `cfg_src_sel`, `cfg_tmo_sel` and `cfg_wdt_en` only between test phases, after the request has dropped. It drives every strobe for exactly one system clock.

// File: rtl/wdt_pkg.sv
// Package: shared constants and types for the keyed watchdog.
// Assumes nothing beyond IEEE 1800-2017 packages.
package wdt_pkg;

    // The single field value that stops the watchdog at run time
    localparam logic [3:0] WDT_STOP_KEY = 4'b1010;

    // Tick source selection
    typedef enum logic {
        SRC_SYS_DIV4 = 1'b0,
        SRC_SUB_EDGE = 1'b1
    } wdt_src_e;

endpackage

// File: rtl/wdt_tick_gen.sv
// Module: wdt_tick_gen
// Produces a one-cycle watchdog tick in the clk domain. The tick comes either
// from a free-running divide-by-four prescaler or from synchronised rising
// edges of the slow sub-clock.
// Assumes: each sub_clk level lasts at least two clk cycles.
module wdt_tick_gen
    import wdt_pkg::*;
#(
    parameter int PRESC_W     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sub_clk,
    input  wdt_src_e src_sel,
    output logic     raw_tick
);

    logic [PRESC_W-1:0]     presc;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   edge_prev;
    logic                   presc_tick;
    logic                   sub_tick;

    // Free-running prescaler for the system-clock source
    always_ff @(posedge clk) begin
        if (!rst_n) presc <= '0;
        else        presc <= presc + PRESC_W'(1);
    end

    // Synchroniser chain for the asynchronous sub-clock
    genvar gi;
    generate
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
            if (gi == 0) begin : g_first
                // First stage samples the raw sub-clock
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[gi] <= 1'b0;
                    else        sync_q[gi] <= sub_clk;
                end
            end else begin : g_next
                // Later stages shift the sampled value along
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[gi] <= 1'b0;
                    else        sync_q[gi] <= sync_q[gi-1];
                end
            end
        end
    endgenerate

    // Previous synchronised level, for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) edge_prev <= 1'b0;
        else        edge_prev <= sync_q[SYNC_STAGES-1];
    end

    // Source selection of the tick
    always_comb begin
        presc_tick = &presc;
        sub_tick   = sync_q[SYNC_STAGES-1] & ~edge_prev;
        raw_tick   = (src_sel == SRC_SUB_EDGE) ? sub_tick : presc_tick;
    end

endmodule

// File: rtl/wdt_key_reg.sv
// Module: wdt_key_reg
// Holds the 4-bit run-time enable field. Resets to the stop key. Flags when
// the field holds the stop key, and pulses a restart on any write of another
// value.
// Assumes: key_wdata is valid whenever key_we is high.
module wdt_key_reg
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_we,
    input  logic [3:0] key_wdata,
    output logic [3:0] field_q,
    output logic       stopped,
    output logic       restart
);

    // Field storage with the stop key as its reset value
    always_ff @(posedge clk) begin
        if (!rst_n)      field_q <= WDT_STOP_KEY;
        else if (key_we) field_q <= key_wdata;
    end

    // Decode of the stored field and of the incoming write
    always_comb begin
        stopped = (field_q == WDT_STOP_KEY);
        restart = key_we && (key_wdata != WDT_STOP_KEY);
    end

endmodule

// File: rtl/wdt_counter.sv
// Module: wdt_counter
// Time-out counter. Counts ticks while running, wraps to zero and raises the
// reset request at the selected power-of-two limit, and drops the request on
// the next source tick.
// Assumes: tmo_sel is stable while the counter runs.
module wdt_counter #(
    parameter int BASE_EXP = 13,
    parameter int SEL_W    = 2,
    parameter int CNT_W    = BASE_EXP + (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             tick,
    input  logic             clr,
    input  logic             restart,
    input  logic [SEL_W-1:0] tmo_sel,
    output logic [CNT_W-1:0] cnt,
    output logic             req
);

    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] term;
    logic             ctick;
    logic             ovf;

    // Terminal count for the selected time-out and the overflow condition
    always_comb begin
        span  = {{CNT_W{1'b0}}, 1'b1} << (BASE_EXP + int'(tmo_sel));
        term  = span[CNT_W-1:0] - CNT_W'(1);
        ctick = tick && running;
        ovf   = ctick && !clr && !restart && (cnt == term);
    end

    // Counter: held at zero when stopped, zeroed by clear or restart
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt <= '0;
        else if (!running || clr || restart) cnt <= '0;
        else if (ctick)                      cnt <= (cnt == term) ? '0 : cnt + CNT_W'(1);
    end

    // Reset request: set on overflow, released on the following source tick
    always_ff @(posedge clk) begin
        if (!rst_n)          req <= 1'b0;
        else if (ovf)        req <= 1'b1;
        else if (req && tick) req <= 1'b0;
    end

endmodule

// File: rtl/keyed_watchdog.sv
// Module: keyed_watchdog (top)
// Watchdog timer with a configuration enable, a selectable tick source, a
// selectable power-of-two time-out, and a 4-bit run-time field that stops the
// counter only when it holds the stop key.
// Assumes: a single system clock; sub_clk is slow and asynchronous.
module keyed_watchdog
    import wdt_pkg::*;
#(
    parameter int TMO_BASE_EXP = 13,
    parameter int TMO_SEL_W    = 2,
    localparam int CNT_W       = TMO_BASE_EXP + (1 << TMO_SEL_W) - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sub_clk,
    input  logic                 cfg_wdt_en,
    input  logic                 cfg_src_sel,
    input  logic [TMO_SEL_W-1:0] cfg_tmo_sel,
    input  logic                 key_we,
    input  logic [3:0]           key_wdata,
    input  logic                 clr_wdt,
    output logic [3:0]           field_q,
    output logic                 wdt_rst_req
);

    logic             raw_tick;
    logic             stopped;
    logic             restart;
    logic             running;
    logic             clr_eff;
    logic [CNT_W-1:0] wd_cnt;
    wdt_src_e         src_sel;

    // Run condition, gated clear and source decode
    always_comb begin
        running = cfg_wdt_en && !stopped;
        clr_eff = cfg_wdt_en && clr_wdt;
        src_sel = wdt_src_e'(cfg_src_sel);
    end

    wdt_tick_gen #(
        .PRESC_W    (2),
        .SYNC_STAGES(2)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .sub_clk (sub_clk),
        .src_sel (src_sel),
        .raw_tick(raw_tick)
    );

    wdt_key_reg u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_we   (key_we),
        .key_wdata(key_wdata),
        .field_q  (field_q),
        .stopped  (stopped),
        .restart  (restart)
    );

    wdt_counter #(
        .BASE_EXP(TMO_BASE_EXP),
        .SEL_W   (TMO_SEL_W),
        .CNT_W   (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .running(running),
        .tick   (raw_tick),
        .clr    (clr_eff),
        .restart(restart),
        .tmo_sel(cfg_tmo_sel),
        .cnt    (wd_cnt),
        .req    (wdt_rst_req)
    );

endmodule

// File: rtl/wdt_checker.sv
// Module: wdt_checker
// Temporal properties of keyed_watchdog, attached by bind.
// Assumes: the input rules given in the brief's verification section.
module wdt_checker #(
    parameter int BASE_EXP = 13,
    parameter int SEL_W    = 2,
    parameter int CNT_W    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wdt_en,
    input logic [SEL_W-1:0] cfg_tmo_sel,
    input logic             clr_wdt,
    input logic             key_we,
    input logic [3:0]       key_wdata,
    input logic [3:0]       field_q,
    input logic             wdt_rst_req,
    input logic [CNT_W-1:0] cnt,
    input logic             raw_tick
);

    function automatic logic [CNT_W-1:0] last_count(input logic [SEL_W-1:0] s);
        logic [CNT_W:0] one_hot;
        one_hot = {{CNT_W{1'b0}}, 1'b1} << (BASE_EXP + int'(s));
        return one_hot[CNT_W-1:0] - CNT_W'(1);
    endfunction

    // R1: the counter either holds, steps by one, or returns to zero
    p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (cnt == '0 || cnt == $past(cnt) + CNT_W'(1)));

    // R1: the request rises only after a tick at the terminal count
    p_req_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst_req) |-> ($past(raw_tick) && $past(cnt) == last_count($past(cfg_tmo_sel))));

    // R4: the stop key holds the counter at zero
    p_stop_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (field_q == 4'b1010) |=> (cnt == '0));

    // R6: with the configuration enable off, nothing counts
    p_cfg_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wdt_en |=> (cnt == '0));

    // R7: a clear while enabled zeroes the counter
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wdt_en && clr_wdt) |=> (cnt == '0));

    // R8: a write of a running value zeroes the counter
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (key_we && key_wdata != 4'b1010) |=> (cnt == '0));

    // R9: the request drops only on a source tick
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_rst_req) |-> $past(raw_tick));

endmodule

bind keyed_watchdog wdt_checker #(
    .BASE_EXP(TMO_BASE_EXP),
    .SEL_W   (TMO_SEL_W),
    .CNT_W   (CNT_W)
) u_wdt_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wdt_en (cfg_wdt_en),
    .cfg_tmo_sel(cfg_tmo_sel),
    .clr_wdt    (clr_wdt),
    .key_we     (key_we),
    .key_wdata  (key_wdata),
    .field_q    (field_q),
    .wdt_rst_req(wdt_rst_req),
    .cnt        (wd_cnt),
    .raw_tick   (raw_tick)
);

// File: tb/keyed_watchdog_bench.sv
// Bench for keyed_watchdog. A behavioural model runs alongside the design and
// is compared on every clock; directed phases add requirement-tagged checks.
module keyed_watchdog_bench;

    localparam int BASE = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sub_clk = 1'b0;
    logic       cfg_wdt_en = 1'b1;
    logic       cfg_src_sel = 1'b0;
    logic [1:0] cfg_tmo_sel = 2'd0;
    logic       key_we = 1'b0;
    logic [3:0] key_wdata = 4'd0;
    logic       clr_wdt = 1'b0;
    logic [3:0] field_q;
    logic       wdt_rst_req;

    int    n_checks = 0;
    int    n_fail = 0;
    string phase = "R5";

    always #4 clk = ~clk;

    keyed_watchdog #(.TMO_BASE_EXP(BASE)) u_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .sub_clk(sub_clk), .cfg_wdt_en(cfg_wdt_en),
        .cfg_src_sel(cfg_src_sel), .cfg_tmo_sel(cfg_tmo_sel), .key_we(key_we),
        .key_wdata(key_wdata), .clr_wdt(clr_wdt), .field_q(field_q),
        .wdt_rst_req(wdt_rst_req)
    );

    // Behavioural reference model
    int m_ps, m_s1, m_s2, m_sp, m_cnt, m_req, m_field;
    always @(posedge clk) begin
        int  lim;
        bit  raw, run, rst_cnt, ovf;
        if (!rst_n) begin
            m_ps = 0; m_s1 = 0; m_s2 = 0; m_sp = 0; m_cnt = 0; m_req = 0; m_field = 10;
        end else begin
            lim     = 1 << (BASE + int'(cfg_tmo_sel));
            raw     = cfg_src_sel ? (m_s2 == 1 && m_sp == 0) : (m_ps == 3);
            run     = cfg_wdt_en && m_field != 10;
            rst_cnt = (key_we && key_wdata != 4'd10) || (clr_wdt && cfg_wdt_en);
            ovf     = run && raw && !rst_cnt && m_cnt == lim - 1;
            if (ovf) m_req = 1;
            else if (m_req == 1 && raw) m_req = 0;
            if (!run || rst_cnt) m_cnt = 0;
            else if (raw) m_cnt = (m_cnt == lim - 1) ? 0 : m_cnt + 1;
            if (key_we) m_field = int'(key_wdata);
            m_ps = (m_ps + 1) % 4; m_sp = m_s2; m_s2 = m_s1; m_s1 = int'(sub_clk);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(wdt_rst_req == m_req[0], phase, int'(wdt_rst_req), m_req);
            check(int'(field_q) == m_field, phase, int'(field_q), m_field);
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] v);
        @(negedge clk); key_we = 1'b1; key_wdata = v;
        @(negedge clk); key_we = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            sub_clk = 1'b1; wait_clk(3);
            sub_clk = 1'b0; wait_clk(3);
        end
    endtask

    task automatic clr();
        @(negedge clk); clr_wdt = 1'b1;
        @(negedge clk); clr_wdt = 1'b0;
    endtask

    // Clocks from now until the request rises, capped
    task automatic time_to_req(output int n);
        n = 0;
        while (!wdt_rst_req && n < 3000) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Watchdog on the run itself
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired, run hung");
        summary();
        $finish;
    end

    initial begin
        int n;
        wait_clk(5);
        rst_n = 1'b1;
        // R5: reset value of the field and no request
        @(negedge clk);
        check(field_q == 4'b1010, "R5", int'(field_q), 10);
        wait_clk(200);
        check(wdt_rst_req == 1'b0, "R5", int'(wdt_rst_req), 0);

        // R2/R3/R1: sub-clock source, shortest time-out
        phase = "R1"; cfg_src_sel = 1'b1; cfg_tmo_sel = 2'd0;
        wr(4'h0);
        pulses(31); wait_clk(4);
        check(wdt_rst_req == 1'b0, "R3", int'(wdt_rst_req), 0);
        pulses(1); wait_clk(2);
        check(wdt_rst_req == 1'b1, "R1", int'(wdt_rst_req), 1);
        // R9: request held while no tick arrives, dropped by the next tick
        phase = "R9"; wait_clk(20);
        check(wdt_rst_req == 1'b1, "R9", int'(wdt_rst_req), 1);
        pulses(1); wait_clk(2);
        check(wdt_rst_req == 1'b0, "R9", int'(wdt_rst_req), 0);

        // R3: second time-out step
        phase = "R3"; cfg_tmo_sel = 2'd1; wr(4'h5);
        pulses(63); wait_clk(4);
        check(wdt_rst_req == 1'b0, "R3", int'(wdt_rst_req), 0);
        pulses(1);
        check(wdt_rst_req == 1'b1, "R3", int'(wdt_rst_req), 1);
        pulses(1);

        // R8: rewrite of a running value restarts the period
        phase = "R8"; wr(4'h3); pulses(40); wr(4'hC); pulses(40);
        check(wdt_rst_req == 1'b0, "R8", int'(wdt_rst_req), 0);
        pulses(24);
        check(wdt_rst_req == 1'b1, "R8", int'(wdt_rst_req), 1);
        pulses(1);

        // R7: clear restarts the period
        phase = "R7"; wr(4'h1); pulses(50); clr(); pulses(50);
        check(wdt_rst_req == 1'b0, "R7", int'(wdt_rst_req), 0);
        pulses(14);
        check(wdt_rst_req == 1'b1, "R7", int'(wdt_rst_req), 1);
        pulses(1);

        // R2: sub-clock source gives no tick without edges
        phase = "R2"; wr(4'h0); wait_clk(2000);
        check(wdt_rst_req == 1'b0, "R2", int'(wdt_rst_req), 0);

        // R6: configuration enable off, clears ignored, no request
        phase = "R6"; cfg_wdt_en = 1'b0; wr(4'h0);
        for (int i = 0; i < 10; i++) begin pulses(10); clr(); end
        check(wdt_rst_req == 1'b0, "R6", int'(wdt_rst_req), 0);
        check(field_q == 4'h0, "R6", int'(field_q), 0);
        cfg_wdt_en = 1'b1;

        // R4: stop key holds the counter
        phase = "R4"; wr(4'b1010); pulses(100);
        check(wdt_rst_req == 1'b0, "R4", int'(wdt_rst_req), 0);

        // R4/R2: every other key value runs, system clock / 4 source
        cfg_src_sel = 1'b0; cfg_tmo_sel = 2'd0; wait_clk(4);
        for (int v = 0; v < 16; v++) begin
            if (v != 10) begin
                wr(4'(v));
                time_to_req(n);
                check(n >= 124 && n <= 132, "R4", n, 128);
                wait_clk(8);
            end
        end

        // R3: longest time-out on the system clock / 4 source
        phase = "R3"; wr(4'b1010); cfg_tmo_sel = 2'd3; wait_clk(4);
        wr(4'h6); time_to_req(n);
        check(n >= 1020 && n <= 1028, "R3", n, 1024);
        wait_clk(8);

        summary();
        $finish;
    end

endmodule